// File: doc/BRIEF.md
# Halfword Register Slave for an AHB-Lite Bus

This block is an AHB-Lite slave that holds a small set of 16-bit fields. The fields are grouped into register instances of two fields each. With the default two instances there are four fields, packed two per 32-bit word, in an 8-byte window that starts at address zero. A bus master reads and writes the fields in single transfers or in back-to-back incrementing runs, using byte, halfword or word transfers. Every access inside the window completes with no wait states. Every access outside the window gets the two-cycle ERROR response.

Each field also has a hardware load port with an enable and a parallel value, so that on-chip logic can set the field without using the bus. The current value of every field is always driven out on a flat output bus, so that logic can observe it. If the bus and the load port write the same field in the same cycle, the bus write wins.

Top module: `ahb_reg_slave`

## Requirements
- R1: Field k (k = 0..3) sits at byte offset 2k. Byte offset 4i holds field one of instance i and byte offset 4i+2 holds field two of instance i. Field k is driven on `fieldQ[16k+15:16k]`.
- R2: A halfword transfer uses data lanes [15:0] when HADDR[1] is 0 and lanes [31:16] when HADDR[1] is 1. A read returns the whole addressed word, so lanes [15:0] carry the even field and lanes [31:16] carry the odd field.
- R3: A word write at offset 4i writes lanes [15:0] into field 2i and lanes [31:16] into field 2i+1 in the same cycle.
- R4: An address phase is accepted when HSEL, HREADY and HTRANS[1] are all high. Write data is taken in the following cycle. Back-to-back transfers with rising addresses complete one per cycle, and a read that directly follows a write to the same field returns the new value.
- R5: An accepted transfer whose address is 8 or above is answered in two cycles. The first cycle has HRESP=1 and HREADYOUT=0. The second cycle has HRESP=1 and HREADYOUT=1. No field changes.
- R6: HRESP=1 together with HREADYOUT=1 only ever appears in the cycle directly after a cycle with HRESP=1 and HREADYOUT=0.
- R7: The data phase of every in-window transfer has HREADYOUT=1 and HRESP=0.
- R8: When `hwWrEn[k]` is high at a rising clock edge and no bus write targets field k, the field takes `hwIn[16k+15:16k]`. A later bus read returns that value.
- R9: While `hwWrEn[k]` is low, changes on `hwIn` leave field k unchanged.
- R10: If a bus write data phase and `hwWrEn[k]` both target field k at the same edge, the field takes the bus data.
- R11: Transfers with HTRANS IDLE (00) or BUSY (01) write nothing and get a zero-wait OKAY response.
- R12: While `rstN` is low, all fields clear to 0, HREADYOUT is 1 and HRESP is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hSel | input | 1 | Slave select |
| hAddr | input | 32 | Transfer address |
| hTrans | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| hWrite | input | 1 | 1 = write, 0 = read |
| hSize | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| hWdata | input | 32 | Write data, valid in the data phase |
| hReady | input | 1 | Bus-wide ready, previous transfer done |
| hRdata | output | 32 | Read data of the addressed word |
| hReadyOut | output | 1 | Slave ready |
| hResp | output | 1 | 1 = ERROR response |
| hwWrEn | input | 4 | Hardware load enable, one bit per field |
| hwIn | input | 64 | Hardware load values, 16 bits per field |
| fieldQ | output | 64 | Current field values, 16 bits per field |

## Verification
The properties assume a master that obeys the protocol. It drives a new address phase only after HREADY has been seen high, it keeps HREADY tied to this slave's HREADYOUT, and it never drops HSEL in the middle of a transfer. The bench acts as that master: every beat starts one clock after the previous one, HREADY is wired straight back from HREADYOUT, and only IDLE is issued while an ERROR response is in progress. The hardware-load properties assume `hwWrEn` changes only between edges, which the bench ensures by driving it one nanosecond after each rising edge.

// File: rtl/ahb_reg_pkg.sv
package ahb_reg_pkg;
  localparam int FIELD_W = 16;
  localparam int WORD_W  = 2 * FIELD_W;
  localparam int LANES   = WORD_W / 8;
  localparam int WSEL_W  = 8;

  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    RS_OKAY = 2'd0,
    RS_ERR1 = 2'd1,
    RS_ERR2 = 2'd2
  } rspState_e;

  typedef struct packed {
    logic              busWr;
    logic [LANES-1:0]  laneEn;
    logic [WSEL_W-1:0] wordSel;
  } dpStrobe_t;
endpackage

// File: rtl/ahb_reg_ctrl.sv
module ahb_reg_ctrl
  import ahb_reg_pkg::*;
#(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSel,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic [1:0]        hTrans,
  input  logic              hWrite,
  input  logic [2:0]        hSize,
  input  logic              hReady,
  output logic              hReadyOut,
  output logic              hResp,
  output dpStrobe_t         strobe
);
  localparam int WIN_BYTES = NUM_INST * 4;

  logic              addrPhase;
  logic              inWin;
  logic              dpWr;
  logic [1:0]        dpOff;
  logic [1:0]        dpSize;
  logic [WSEL_W-1:0] dpWord;
  rspState_e         rspState, rspNext;

  assign addrPhase = hSel && hReady && hTrans[1];
  assign inWin     = (hAddr < ADDR_W'(WIN_BYTES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpWr   <= 1'b0;
      dpOff  <= '0;
      dpSize <= '0;
      dpWord <= '0;
    end else if (hReady) begin
      dpWr <= addrPhase && inWin && hWrite;
      if (addrPhase) begin
        dpOff  <= hAddr[1:0];
        dpSize <= hSize[1:0];
        dpWord <= hAddr[WSEL_W+1:2];
      end
    end
  end

  always_comb begin
    rspNext = RS_OKAY;
    unique case (rspState)
      RS_ERR1: rspNext = RS_ERR2;
      default: rspNext = (addrPhase && !inWin) ? RS_ERR1 : RS_OKAY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspState <= RS_OKAY;
    else       rspState <= rspNext;
  end

  assign hReadyOut = (rspState != RS_ERR1);
  assign hResp     = (rspState != RS_OKAY);

  always_comb begin
    strobe.busWr   = dpWr;
    strobe.wordSel = dpWord;
    unique case (dpSize)
      2'd0:    strobe.laneEn = LANES'(1) << dpOff;
      2'd1:    strobe.laneEn = dpOff[1] ? 4'b1100 : 4'b0011;
      default: strobe.laneEn = '1;
    endcase
  end
endmodule

// File: rtl/ahb_reg_dpath.sv
module ahb_reg_dpath
  import ahb_reg_pkg::*;
#(
  parameter int NUM_INST = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [WORD_W-1:0]             hWdata,
  input  logic [2*NUM_INST-1:0]         hwWrEn,
  input  logic [2*NUM_INST*FIELD_W-1:0] hwIn,
  output logic [WORD_W-1:0]             hRdata,
  output logic [2*NUM_INST*FIELD_W-1:0] fieldQ
);
  localparam int NUM_FIELDS = 2 * NUM_INST;
  localparam int FLD_LANES  = FIELD_W / 8;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int HALF = f % 2;
    logic [FIELD_W-1:0] fldR;
    logic [FIELD_W-1:0] busMerge;
    logic               busHit;

    assign busHit = strobe.busWr && (strobe.wordSel == WSEL_W'(f / 2)) &&
                    (|strobe.laneEn[HALF*FLD_LANES +: FLD_LANES]);

    always_comb begin
      busMerge = fldR;
      for (int b = 0; b < FLD_LANES; b++) begin
        if (strobe.laneEn[HALF*FLD_LANES + b])
          busMerge[b*8 +: 8] = hWdata[(HALF*FLD_LANES + b)*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          fldR <= '0;
      else if (busHit)    fldR <= busMerge;
      else if (hwWrEn[f]) fldR <= hwIn[f*FIELD_W +: FIELD_W];
    end

    assign fieldQ[f*FIELD_W +: FIELD_W] = fldR;
  end

  always_comb begin
    hRdata = '0;
    for (int i = 0; i < NUM_INST; i++) begin
      if (strobe.wordSel == WSEL_W'(i)) hRdata = fieldQ[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/ahb_reg_slave.sv
module ahb_reg_slave
  import ahb_reg_pkg::*;
#(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hSel,
  input  logic [ADDR_W-1:0]             hAddr,
  input  logic [1:0]                    hTrans,
  input  logic                          hWrite,
  input  logic [2:0]                    hSize,
  input  logic [WORD_W-1:0]             hWdata,
  input  logic                          hReady,
  output logic [WORD_W-1:0]             hRdata,
  output logic                          hReadyOut,
  output logic                          hResp,
  input  logic [2*NUM_INST-1:0]         hwWrEn,
  input  logic [2*NUM_INST*FIELD_W-1:0] hwIn,
  output logic [2*NUM_INST*FIELD_W-1:0] fieldQ
);
  dpStrobe_t strobe;

  ahb_reg_ctrl #(.NUM_INST(NUM_INST), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hAddr(hAddr), .hTrans(hTrans),
    .hWrite(hWrite), .hSize(hSize), .hReady(hReady),
    .hReadyOut(hReadyOut), .hResp(hResp), .strobe(strobe)
  );

  ahb_reg_dpath #(.NUM_INST(NUM_INST)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hWdata(hWdata),
    .hwWrEn(hwWrEn), .hwIn(hwIn), .hRdata(hRdata), .fieldQ(fieldQ)
  );
endmodule

// File: rtl/ahb_reg_slave_chk.sv
module ahb_reg_slave_chk
  import ahb_reg_pkg::*;
#(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          hSel,
  input logic [ADDR_W-1:0]             hAddr,
  input logic [1:0]                    hTrans,
  input logic                          hWrite,
  input logic [2:0]                    hSize,
  input logic [WORD_W-1:0]             hWdata,
  input logic                          hReady,
  input logic [WORD_W-1:0]             hRdata,
  input logic                          hReadyOut,
  input logic                          hResp,
  input logic [2*NUM_INST-1:0]         hwWrEn,
  input logic [2*NUM_INST*FIELD_W-1:0] hwIn,
  input logic [2*NUM_INST*FIELD_W-1:0] fieldQ
);
  localparam int WIN_BYTES = NUM_INST * 4;

  logic accepted, winHit, wrPend;
  assign accepted = hSel && hReady && hTrans[1];
  assign winHit   = hAddr < ADDR_W'(WIN_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       wrPend <= 1'b0;
    else if (hReady) wrPend <= accepted && winHit && hWrite;
  end

  // R5: first error cycle
  p_err_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !winHit) |=> (hResp && !hReadyOut));

  // R5: second error cycle
  p_err_second_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hResp && !hReadyOut) |=> (hResp && hReadyOut));

  // R6: ready-with-error only after the stalled error cycle
  p_err_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hResp && hReadyOut) |-> $past(hResp && !hReadyOut));

  // R7: legal transfers get a zero-wait OKAY
  p_zero_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && winHit) |=> (hReadyOut && !hResp));

  // R11: no accepted transfer means no stall
  p_idle_ok_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hReady && !(hSel && hTrans[1])) |=> hReadyOut);

  for (genvar f = 0; f < 2*NUM_INST; f++) begin : g_fchk
    // R8: hardware load
    p_hw_load_r8: assert property (@(posedge clk) disable iff (!rstN)
      (hwWrEn[f] && !wrPend) |=> (fieldQ[f*FIELD_W +: FIELD_W] == $past(hwIn[f*FIELD_W +: FIELD_W])));
    // R9: field holds with no load and no bus write
    p_hw_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (!hwWrEn[f] && !wrPend) |=> $stable(fieldQ[f*FIELD_W +: FIELD_W]));
  end
endmodule

bind ahb_reg_slave ahb_reg_slave_chk #(.NUM_INST(NUM_INST), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/ahb_reg_slave_tb_top.sv
`timescale 1ns/1ps
module ahb_reg_slave_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hSel = 1'b1;
  logic [31:0] hAddr = '0;
  logic [1:0]  hTrans = 2'b00;
  logic        hWrite = 1'b0;
  logic [2:0]  hSize = 3'd2;
  logic [31:0] hWdata = '0;
  logic        hReady;
  logic [31:0] hRdata;
  logic        hReadyOut, hResp;
  logic [3:0]  hwWrEn = '0;
  logic [63:0] hwIn = '0;
  logic [63:0] fieldQ;

  always #2.5 clk = ~clk;
  assign hReady = hReadyOut;

  ahb_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hAddr(hAddr), .hTrans(hTrans),
    .hWrite(hWrite), .hSize(hSize), .hWdata(hWdata), .hReady(hReady),
    .hRdata(hRdata), .hReadyOut(hReadyOut), .hResp(hResp),
    .hwWrEn(hwWrEn), .hwIn(hwIn), .fieldQ(fieldQ)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [15:0] mdl [4];
  logic [31:0] expQ [$];
  string       tagQ [$];
  string       curTag = "R1";
  logic        pendRd = 0, pendLeg = 0, dataRd = 0, dataLeg = 0;
  logic [31:0] pendWd = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] laneMask(input logic [2:0] sz, input logic [1:0] off);
    if (sz == 3'd0) return 4'b0001 << off;
    if (sz == 3'd1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  // driver: one beat per cycle, data phase of previous beat in same slot
  task automatic beat(input logic [31:0] a, input logic [2:0] sz, input logic wr,
                      input logic [31:0] wd, input logic [1:0] tr);
    logic act, leg;
    logic [3:0] m;
    int w;
    @(posedge clk); #1;
    hWdata = pendWd; dataRd = pendRd; dataLeg = pendLeg;
    hAddr = a; hSize = sz; hWrite = wr; hTrans = tr;
    act = tr[1];
    leg = act && (a < 32'd8);
    w = int'(a[2]);
    if (leg && !wr) begin
      expQ.push_back({mdl[2*w+1], mdl[2*w]});
      tagQ.push_back(curTag);
    end
    if (leg && wr) begin
      m = laneMask(sz, a[1:0]);
      for (int b = 0; b < 4; b++)
        if (m[b]) begin
          if (b < 2) mdl[2*w][b*8 +: 8]     = wd[b*8 +: 8];
          else       mdl[2*w+1][(b-2)*8 +: 8] = wd[b*8 +: 8];
        end
    end
    pendRd = leg && !wr; pendLeg = leg; pendWd = wd;
  endtask

  task automatic idle();
    beat(32'h0, 3'd2, 1'b0, 32'h0, 2'b00);
  endtask

  task automatic checkFields(input string tag);
    @(negedge clk);
    for (int k = 0; k < 4; k++)
      chk(fieldQ[16*k +: 16] == mdl[k], tag, 64'(fieldQ[16*k +: 16]), 64'(mdl[k]));
  endtask

  task automatic errSeq(input logic [31:0] a, input logic wr);
    beat(a, 3'd2, wr, 32'hDEAD_BEEF, 2'b10);
    idle();
    @(negedge clk);
    chk(hResp && !hReadyOut, "R5 first", {62'b0, hResp, hReadyOut}, 64'b10);
    idle();
    @(negedge clk);
    chk(hResp && hReadyOut, "R6 second", {62'b0, hResp, hReadyOut}, 64'b11);
    idle();
    @(negedge clk);
    chk(!hResp && hReadyOut, "R5 recover", {62'b0, hResp, hReadyOut}, 64'b01);
  endtask

  // monitor: scoreboard pop and zero-wait check in each data phase
  always @(negedge clk) begin
    if (rstN && dataLeg)
      chk(hReadyOut && !hResp, "R7", {62'b0, hReadyOut, hResp}, 64'b10);
    if (rstN && dataRd) begin
      if (expQ.size() == 0) chk(1'b0, "R4 empty queue", 64'(hRdata), 64'h0);
      else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(hRdata == e, t, 64'(hRdata), 64'(e));
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    hwIn = 64'h1111_2222_3333_4444;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(fieldQ == 64'h0, "R12 fields", fieldQ, 64'h0);
    chk(hReadyOut == 1'b1, "R12 ready", 64'(hReadyOut), 64'h1);
    chk(hResp == 1'b0, "R12 resp", 64'(hResp), 64'h0);
    @(posedge clk); #1 rstN = 1'b1;

    // R1/R4: incrementing halfword burst writes
    curTag = "R4";
    beat(32'h0, 3'd1, 1'b1, 32'h0000_A0A0, 2'b10);
    beat(32'h2, 3'd1, 1'b1, 32'hB1B1_0000, 2'b11);
    beat(32'h4, 3'd1, 1'b1, 32'h0000_C2C2, 2'b11);
    beat(32'h6, 3'd1, 1'b1, 32'hD3D3_0000, 2'b11);
    idle(); idle();
    checkFields("R1 field map");
    curTag = "R1";
    beat(32'h0, 3'd2, 1'b0, 32'h0, 2'b10);
    beat(32'h4, 3'd2, 1'b0, 32'h0, 2'b11);
    idle(); idle();

    // R2: halfword reads of odd fields
    curTag = "R2";
    beat(32'h2, 3'd1, 1'b0, 32'h0, 2'b10);
    beat(32'h6, 3'd1, 1'b0, 32'h0, 2'b10);
    idle(); idle();

    // R3: word write updates both fields of instance 1
    curTag = "R3";
    beat(32'h4, 3'd2, 1'b1, 32'hBEEF_CAFE, 2'b10);
    idle(); idle();
    checkFields("R3 word write");
    beat(32'h4, 3'd1, 1'b0, 32'h0, 2'b10);
    idle(); idle();

    // R4: read directly after write to same field; byte write
    curTag = "R4";
    beat(32'h0, 3'd1, 1'b1, 32'h0000_5A5A, 2'b10);
    beat(32'h0, 3'd1, 1'b0, 32'h0, 2'b10);
    beat(32'h3, 3'd0, 1'b1, 32'h7700_0000, 2'b10);
    beat(32'h0, 3'd2, 1'b0, 32'h0, 2'b10);
    idle(); idle();
    checkFields("R4 byte write");

    // R8: hardware load of fields 1 and 3
    curTag = "R8";
    @(posedge clk); #1;
    hwIn = 64'h9876_0000_1234_0000; hwWrEn = 4'b1010;
    mdl[1] = 16'h1234; mdl[3] = 16'h9876;
    @(posedge clk); #1 hwWrEn = 4'b0000;
    checkFields("R8 hw load");
    beat(32'h0, 3'd2, 1'b0, 32'h0, 2'b10);
    beat(32'h4, 3'd2, 1'b0, 32'h0, 2'b11);
    idle(); idle();

    // R9: hardware input toggles with enable low
    curTag = "R9";
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 hwIn = {4{16'hF00D + 16'(i)}};
    end
    checkFields("R9 hold");
    beat(32'h0, 3'd2, 1'b0, 32'h0, 2'b10);
    beat(32'h4, 3'd2, 1'b0, 32'h0, 2'b11);
    idle(); idle();

    // R10: bus and hardware hit field 0 at the same edge
    curTag = "R10";
    beat(32'h0, 3'd1, 1'b1, 32'h0000_0B05, 2'b10);
    idle();
    hwIn = 64'h0000_0000_0000_4848; hwWrEn = 4'b0001;
    @(posedge clk); #1 hwWrEn = 4'b0000;
    checkFields("R10 bus wins");

    // R11: BUSY and IDLE write attempts ignored
    beat(32'h0, 3'd1, 1'b1, 32'h0000_EEEE, 2'b01);
    beat(32'h2, 3'd1, 1'b1, 32'hEEEE_0000, 2'b00);
    idle();
    @(negedge clk);
    chk(hReadyOut && !hResp, "R11 okay", {62'b0, hReadyOut, hResp}, 64'b10);
    checkFields("R11 no write");

    // R5/R6: out-of-window write and reads
    errSeq(32'h8, 1'b1);
    errSeq(32'hC, 1'b0);
    errSeq(32'h538, 1'b1);
    checkFields("R5 no change");
    curTag = "R5";
    beat(32'h0, 3'd2, 1'b0, 32'h0, 2'b10);
    idle(); idle();

    repeat (2) @(posedge clk);
    chk(expQ.size() == 0, "R4 queue drained", 64'(expQ.size()), 64'h0);
    summary();
  end
endmodule